// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts video scanlines and interrupts the CPU once a programmed number of them has passed. Software sees four write-only actions, selected by the top three address bits and address bit 0. It can store a reload value, ask for the counter to be refilled from that value, and switch the interrupt off or on. Either of the last two writes also clears an interrupt that is waiting.

The scanline input is a clean pulse, one clock cycle wide, once per line. On each pulse the counter is refilled from the stored value if it is zero or if a refill has been requested. Otherwise it counts down by one. When the pulse leaves the counter at zero and the interrupt is switched on, a sticky pending flag is set. The active-low interrupt line follows that flag.

Top module: `scan_irq_top`

## Requirements
- R1: When the synchronous reset is released, irq_n is 1 and the enable, counter, reload value and refill request are all zero. The first tick after the interrupt is switched on therefore leaves the counter at zero and raises the request.
- R2: A write acts only when wr_addr[15:13] is 3'b110 (counter group) or 3'b111 (interrupt group). Writes with any other top bits change nothing. Within a group, only wr_addr[0] selects the action.
- R3: A write to the counter group with wr_addr[0]=0 stores wr_data as the reload value. It does not move the counter until a later tick.
- R4: A write to the counter group with wr_addr[0]=1 sets the refill request. The next tick loads the reload value, whatever the counter holds.
- R5: On a tick, the counter loads the reload value if it is zero or a refill is requested, and the request is cleared. Otherwise the counter decrements by one. Without a tick the counter holds.
- R6: If the counter is zero after a tick and the interrupt was enabled before that clock edge, the pending flag is set.
- R7: The pending flag stays set until any write to the interrupt group. Such a write clears it, and the clear wins over a tick in the same cycle that would set it.
- R8: A write to the interrupt group with wr_addr[0]=0 disables the interrupt. With wr_addr[0]=1 it enables it. While disabled, reaching zero sets no request.
- R9: irq_n is the inverse of the pending flag. It changes in the cycle after the clock edge that updates the flag.
- R10: With a reload value of zero and the interrupt enabled, every tick raises the request again.
- R11: A tick in the same cycle as a reload-value write uses the old value. A refill write in the same cycle as a tick leaves the request set for the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that line_tick is a single-cycle pulse sampled on the same clock as the write port. They also assume that a write lasts exactly one cycle with a stable address. The stimulus drives both inputs only on the falling edge and holds them for one full cycle. It draws addresses from the two active groups and from inactive regions, with random low bits. Random ticks are mixed with writes in the same cycle, so the same-cycle priority cases in R7 and R11 are covered under the same input assumptions.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

    localparam int GROUP_W = 3;
    localparam logic [GROUP_W-1:0] GRP_COUNT = 3'b110;
    localparam logic [GROUP_W-1:0] GRP_IRQ   = 3'b111;

    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_COUNT = 2'd1,
        RG_IRQ   = 2'd2
    } region_e;

    typedef struct packed {
        logic set_value;
        logic ask_refill;
        logic irq_off;
        logic irq_on;
    } cmd_t;

    function automatic region_e region_of(input logic [GROUP_W-1:0] grp);
        region_e r;
        case (grp)
            GRP_COUNT: r = RG_COUNT;
            GRP_IRQ:   r = RG_IRQ;
            default:   r = RG_NONE;
        endcase
        return r;
    endfunction

    function automatic cmd_t make_cmd(input logic strobe, input region_e r, input logic odd);
        cmd_t c;
        c = '0;
        if (strobe) begin
            case (r)
                RG_COUNT: begin
                    c.set_value  = !odd;
                    c.ask_refill = odd;
                end
                RG_IRQ: begin
                    c.irq_off = !odd;
                    c.irq_on  = odd;
                end
                default: c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/scan_irq_decode.sv
module scan_irq_decode
    import scan_irq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output cmd_t              cmd
);
    localparam int TOP = ADDR_W - 1;

    region_e region;

    always_comb begin
        region = region_of(wr_addr[TOP -: GROUP_W]);
        cmd    = make_cmd(wr_en, region, wr_addr[0]);
    end
endmodule

// File: rtl/scan_irq_counter.sv
module scan_irq_counter
    import scan_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             line_tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] latch_q,
    output logic             reload_q,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d;
    logic             reload_d;
    logic             refill;

    always_comb begin
        refill   = (cnt_q == ZERO) || reload_q;
        cnt_d    = cnt_q;
        reload_d = reload_q;
        if (line_tick) begin
            cnt_d    = refill ? latch_q : (cnt_q - ONE);
            reload_d = 1'b0;
        end
        if (cmd.ask_refill) begin
            reload_d = 1'b1;
        end
        hit = line_tick && (cnt_d == ZERO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= ZERO;
            latch_q  <= ZERO;
            reload_q <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            reload_q <= reload_d;
            if (cmd.set_value) begin
                latch_q <= wr_data;
            end
        end
    end
endmodule

// File: rtl/scan_irq_flag.sv
module scan_irq_flag
    import scan_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic hit,
    output logic en_q,
    output logic pend_q
);
    logic ack;

    always_comb begin
        ack = cmd.irq_off || cmd.irq_on;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (ack) begin
                pend_q <= 1'b0;
            end else if (hit && en_q) begin
                pend_q <= 1'b1;
            end
            if (cmd.irq_on) begin
                en_q <= 1'b1;
            end else if (cmd.irq_off) begin
                en_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scan_irq_top.sv
module scan_irq_top
    import scan_irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              line_tick,
    output logic              irq_n
);
    cmd_t             cmd;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] latch_q;
    logic             reload_q;
    logic             hit;
    logic             en_q;
    logic             pend_q;

    scan_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cmd     (cmd)
    );

    scan_irq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .wr_data   (wr_data),
        .line_tick (line_tick),
        .cnt_q     (cnt_q),
        .latch_q   (latch_q),
        .reload_q  (reload_q),
        .hit       (hit)
    );

    scan_irq_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .hit    (hit),
        .en_q   (en_q),
        .pend_q (pend_q)
    );

    assign irq_n = !pend_q;
endmodule

// File: rtl/scan_irq_chk.sv
module scan_irq_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              line_tick,
    input logic              irq_n,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  latch,
    input logic              reload,
    input logic              en
);
    logic irq_grp_wr;
    logic refill_wr;

    always_comb begin
        irq_grp_wr = wr_en && (wr_addr[ADDR_W-1 -: 3] == 3'b111);
        refill_wr  = wr_en && (wr_addr[ADDR_W-1 -: 3] == 3'b110) && wr_addr[0];
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_n && cnt == '0 && latch == '0 && !reload && !en));

    assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (rst)
        !line_tick |=> $stable(cnt));

    assert_refill_loads_R4: assert property (@(posedge clk) disable iff (rst)
        (line_tick && reload) |=> (cnt == $past(latch)));

    assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
        (line_tick && !reload && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_fall_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(line_tick));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        irq_grp_wr |=> irq_n);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !irq_grp_wr) |=> !irq_n);

    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(en));

    assert_request_consumed_R11: assert property (@(posedge clk) disable iff (rst)
        (line_tick && !refill_wr) |=> !reload);
endmodule

bind scan_irq_top scan_irq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .line_tick (line_tick),
    .irq_n     (irq_n),
    .cnt       (cnt_q),
    .latch     (latch_q),
    .reload    (reload_q),
    .en        (en_q)
);

// File: tb/sim_scan_irq_top.sv
`timescale 1ns/1ps
module sim_scan_irq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_tick = 1'b0;
    logic        irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state
    bit       m_en, m_rel, m_pend;
    bit [7:0] m_cnt, m_lat;

    always #5 clk = ~clk;

    scan_irq_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_tick(line_tick), .irq_n(irq_n)
    );

    function automatic bit exp_irq_n();
        return !m_pend;
    endfunction

    function automatic void model_step(bit w, bit [15:0] a, bit [7:0] d, bit t);
        bit cgrp, igrp, hit;
        bit [7:0] ncnt;
        bit nrel, nen;
        cgrp = w && (a[15:13] == 3'b110);
        igrp = w && (a[15:13] == 3'b111);
        ncnt = m_cnt; nrel = m_rel; hit = 1'b0; nen = m_en;
        if (t) begin
            ncnt = (m_cnt == 0 || m_rel) ? m_lat : m_cnt - 8'd1;
            nrel = 1'b0;
            hit  = (ncnt == 0);
        end
        if (cgrp && a[0]) nrel = 1'b1;
        if (cgrp && !a[0]) m_lat = d;
        if (igrp) m_pend = 1'b0;
        else if (hit && m_en) m_pend = 1'b1;
        if (igrp) nen = a[0];
        m_cnt = ncnt; m_rel = nrel; m_en = nen;
    endfunction

    task automatic check(string req, bit exp);
        checks++;
        if (irq_n !== exp) begin
            fails++;
            $display("FAIL %s irq_n actual=%b expected=%b at %0t", req, irq_n, exp, $time);
        end
    endtask

    task automatic step(string req, bit w, bit [15:0] a, bit [7:0] d, bit t);
        wr_en = w; wr_addr = a; wr_data = d; line_tick = t;
        model_step(w, a, d, t);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; line_tick = 1'b0;
        check(req, exp_irq_n());
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_en = 0; m_rel = 0; m_pend = 0; m_cnt = 0; m_lat = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 1'b1);                             // reset: idle
        step("R8", 1, 16'hE001, 8'h00, 0);             // enable
        step("R1", 0, 16'h0000, 8'h00, 1);             // zero counter -> request
        check("R6", 1'b0);
        step("R2", 1, 16'h6001, 8'h00, 0);             // outside groups: no ack
        step("R2", 1, 16'hA000, 8'h00, 0);
        step("R7", 1, 16'hE001, 8'h00, 0);             // ack by enable write
        // R3 R4 R5: reload value 3 then refill
        step("R3", 1, 16'hC000, 8'h03, 0);
        step("R4", 1, 16'hC001, 8'h00, 0);
        step("R4", 0, 16'h0000, 8'h00, 1);             // 3
        step("R5", 0, 16'h0000, 8'h00, 1);             // 2
        step("R5", 0, 16'h0000, 8'h00, 1);             // 1
        step("R5", 0, 16'h0000, 8'h00, 1);             // 0 -> request
        check("R9", 1'b0);
        step("R7", 0, 16'h0000, 8'h00, 0);             // sticky
        step("R7", 1, 16'hFFFE, 8'h00, 0);             // disable clears
        // disabled: reach zero silently
        for (int i = 0; i < 5; i++) step("R8", 0, 16'h0000, 8'h00, 1);
        step("R8", 1, 16'hE011, 8'h00, 0);             // enable again (other low bits)
        // R10: value zero -> every tick
        step("R10", 1, 16'hC002, 8'h00, 0);
        step("R10", 1, 16'hC001, 8'h00, 0);
        for (int i = 0; i < 3; i++) begin
            step("R10", 0, 16'h0000, 8'h00, 1);
            step("R10", 1, 16'hE001, 8'h00, 0);
        end
        step("R7", 1, 16'hE001, 8'h00, 1);             // ack wins over hit
        // R11: value write with tick uses old value; refill with tick persists
        step("R11", 1, 16'hC000, 8'h02, 1);
        step("R11", 1, 16'hC001, 8'h00, 1);
        step("R11", 0, 16'h0000, 8'h00, 1);
        step("R11", 0, 16'h0000, 8'h00, 1);
        // random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            bit w, t;
            bit [15:0] a;
            bit [7:0] d;
            int sel;
            w = ($urandom % 3) == 0;
            t = ($urandom % 3) == 0;
            sel = $urandom % 8;
            a = $urandom;
            if (sel < 3) a[15:13] = 3'b110;
            else if (sel < 5) a[15:13] = 3'b111;
            d = (($urandom % 4) == 0) ? 8'h00 : ($urandom % 6);
            step("R5/R6/R7 random", w, a, d, t);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule